// File: doc/BRIEF.md
# I2C Host Start and Pause Control

This block sits beside the host bit sequencer of an I2C controller. It turns a software start action (setting the start bit or writing the transmit buffer) into a request for a Start condition when the bus is idle from this host's view. It turns the same action into a Restart request when the host is already active and waiting at the end of a transfer. It keeps a host-active flag that is set once a Start has gone out and cleared by a completed Stop.

While the host runs, the block watches the falling SCL edges together with the bit position inside the byte. It raises a pause flag that holds SCL low until software has serviced the buffers. There are three pause causes. A full receive buffer pauses on the 7th edge. An empty transmit buffer with bytes still to send pauses on the 8th edge. A restart wait, when restarts are enabled and the count has run out or a NACK came back, pauses on the 9th edge. Each cause has its own release action. The waveform generator reports the completion of Start, Restart and Stop conditions back to this block.

Top module: `i2c_host_pause_ctl`

## Requirements
- R1: After reset, start_req_o, restart_req_o, host_act_o and pause_o are all 0.
- R2: Host control runs only when en_i=1 and mode_i[2]=1 (codes 100, 101, 110 and 111). For every other combination of en_i and mode_i, start_set_i and tx_wr_i raise no request.
- R3: When the host is enabled and not active, a start_set_i or tx_wr_i pulse sets start_req_o on the next cycle. start_req_o holds until cond_sent_i. On that edge start_req_o clears and host_act_o sets.
- R4: While active, a falling SCL edge with bit_pos_i=7 and rx_full_i=1 sets pause_o. Only rx_rd_i clears it.
- R5: While active, a falling SCL edge with bit_pos_i=8, tx_empty_i=1 and byte_cnt_i!=0 sets pause_o. Only tx_wr_i clears it.
- R6: While active, a falling SCL edge with bit_pos_i=9, rsen_i=1, and either byte_cnt_i=0 or ack_stat_i=1 sets pause_o.
- R7: A start_set_i or tx_wr_i pulse during a 9th-edge pause clears pause_o and sets restart_req_o on the same edge. cond_sent_i clears restart_req_o, and host_act_o stays 1.
- R8: During a 7th-edge or 8th-edge pause, start_set_i has no effect. The release action that belongs to the other cause also has no effect.
- R9: A falling SCL edge that meets none of the conditions in R4, R5 and R6 leaves pause_o at 0.
- R10: stop_done_i clears host_act_o. Dropping en_i clears host_act_o, pause_o and both requests on the next edge.
- R11: pause_o is 1 only while host_act_o is 1. start_req_o and restart_req_o are never 1 together. pause_o drives SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| mode_i | input | 3 | Mode code; bit 2 selects host operation |
| scl_fall_i | input | 1 | One-cycle pulse on each falling SCL edge |
| bit_pos_i | input | 4 | Position 1..9 of the falling edge within the byte |
| rx_full_i | input | 1 | Receive buffer full |
| tx_empty_i | input | 1 | Transmit buffer empty |
| byte_cnt_i | input | CNT_W | Remaining byte count |
| ack_stat_i | input | 1 | Last acknowledge was a NACK |
| rsen_i | input | 1 | Restart enable |
| start_set_i | input | 1 | Software sets the start bit (pulse) |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| cond_sent_i | input | 1 | Requested Start or Restart has been sent |
| stop_done_i | input | 1 | Stop condition completed |
| start_req_o | output | 1 | Start condition request |
| restart_req_o | output | 1 | Restart condition request |
| host_act_o | output | 1 | Host owns the bus |
| pause_o | output | 1 | Host paused, SCL held low |

## Verification
The assertions take it for granted that scl_fall_i never pulses while pause_o is 1, because SCL is held low then. They also assume that cond_sent_i comes only while a request is pending, and that stop_done_i does not come during a pause. The bench keeps to these rules. It raises one falling edge at a time, waits for the pause outcome, performs the release, and only then sends cond_sent_i or stop_done_i. It sweeps every bit position together with every combination of the buffer, count, acknowledge and restart-enable inputs.

// File: rtl/i2c_hpc_pkg.sv
package i2c_hpc_pkg;
  typedef enum logic [1:0] {
    PC_NONE = 2'd0,
    PC_RX   = 2'd1,
    PC_TX   = 2'd2,
    PC_RS   = 2'd3
  } pause_cause_e;
endpackage

// File: rtl/hpc_pause_ctl.sv
module hpc_pause_ctl
  import i2c_hpc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int POS_W  = 4,
  parameter int RX_POS = 7,
  parameter int TX_POS = 8,
  parameter int RS_POS = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_en_i,
  input  logic             host_act_i,
  input  logic             pend_i,
  input  logic             scl_fall_i,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic             rx_full_i,
  input  logic             tx_empty_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             ack_stat_i,
  input  logic             rsen_i,
  input  logic             trig_i,
  input  logic             start_set_i,
  input  logic             tx_wr_i,
  input  logic             rx_rd_i,
  output logic             pause_o,
  output logic             rs_release_o
);
  localparam logic [POS_W-1:0] RX_P = POS_W'(RX_POS);
  localparam logic [POS_W-1:0] TX_P = POS_W'(TX_POS);
  localparam logic [POS_W-1:0] RS_P = POS_W'(RS_POS);

  logic         pause_q;
  pause_cause_e cause_q;
  logic         cnt_zero, hit_rx, hit_tx, hit_rs;

  assign cnt_zero = (byte_cnt_i == '0);
  assign hit_rx   = (bit_pos_i == RX_P) && rx_full_i;
  assign hit_tx   = (bit_pos_i == TX_P) && tx_empty_i && !cnt_zero;
  assign hit_rs   = (bit_pos_i == RS_P) && rsen_i && (cnt_zero || ack_stat_i);

  assign rs_release_o = pause_q && (cause_q == PC_RS) && trig_i;
  assign pause_o      = pause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q <= 1'b0;
      cause_q <= PC_NONE;
    end else if (!host_en_i || !host_act_i) begin
      pause_q <= 1'b0;
      cause_q <= PC_NONE;
    end else if (pause_q) begin
      unique case (cause_q)
        PC_RX:   if (rx_rd_i)  begin pause_q <= 1'b0; cause_q <= PC_NONE; end
        PC_TX:   if (tx_wr_i)  begin pause_q <= 1'b0; cause_q <= PC_NONE; end
        PC_RS:   if (trig_i)   begin pause_q <= 1'b0; cause_q <= PC_NONE; end
        default: begin pause_q <= 1'b0; cause_q <= PC_NONE; end
      endcase
    end else if (scl_fall_i && !pend_i) begin
      if (hit_rx) begin
        pause_q <= 1'b1;
        cause_q <= PC_RX;
      end else if (hit_tx) begin
        pause_q <= 1'b1;
        cause_q <= PC_TX;
      end else if (hit_rs) begin
        pause_q <= 1'b1;
        cause_q <= PC_RS;
      end
    end
  end

  // R9
  pause_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_q) |-> $past(scl_fall_i));

  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_q && cause_q == PC_RX && host_en_i && host_act_i && !rx_rd_i) |=> pause_q);

  // R8
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_q && cause_q == PC_TX && host_en_i && host_act_i && !tx_wr_i) |=> pause_q);

  // unused start_set_i reaches here only through trig_i
  logic unused_ok;
  assign unused_ok = start_set_i;
endmodule

// File: rtl/hpc_req_ctl.sv
module hpc_req_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_en_i,
  input  logic trig_i,
  input  logic rs_release_i,
  input  logic cond_sent_i,
  input  logic stop_done_i,
  output logic start_req_o,
  output logic restart_req_o,
  output logic host_act_o
);
  logic start_q, restart_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= 1'b0;
      restart_q <= 1'b0;
      act_q     <= 1'b0;
    end else if (!host_en_i) begin
      start_q   <= 1'b0;
      restart_q <= 1'b0;
      act_q     <= 1'b0;
    end else begin
      if (start_q) begin
        if (cond_sent_i) begin
          start_q <= 1'b0;
          act_q   <= 1'b1;
        end
      end else if (stop_done_i) begin
        act_q     <= 1'b0;
        restart_q <= 1'b0;
      end else if (!act_q && trig_i) begin
        start_q <= 1'b1;
      end

      if (restart_q) begin
        if (cond_sent_i) restart_q <= 1'b0;
      end else if (rs_release_i && !stop_done_i) begin
        restart_q <= 1'b1;
      end
    end
  end

  assign start_req_o   = start_q;
  assign restart_req_o = restart_q;
  assign host_act_o    = act_q;

  // R11
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_q && restart_q));

  // R3
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_q) |-> !$past(act_q));

  // R7
  restart_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restart_q) |-> $past(rs_release_i));

  // R3
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && host_en_i && !cond_sent_i) |=> start_q);
endmodule

// File: rtl/i2c_host_pause_ctl.sv
module i2c_host_pause_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       mode_i,
  input  logic             scl_fall_i,
  input  logic [3:0]       bit_pos_i,
  input  logic             rx_full_i,
  input  logic             tx_empty_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             ack_stat_i,
  input  logic             rsen_i,
  input  logic             start_set_i,
  input  logic             tx_wr_i,
  input  logic             rx_rd_i,
  input  logic             cond_sent_i,
  input  logic             stop_done_i,
  output logic             start_req_o,
  output logic             restart_req_o,
  output logic             host_act_o,
  output logic             pause_o
);
  localparam int HOST_BIT = 2;

  logic host_en, trig, rs_release, pend;

  assign host_en = en_i && mode_i[HOST_BIT];
  assign trig    = host_en && (start_set_i || tx_wr_i);
  assign pend    = start_req_o || restart_req_o;

  hpc_req_ctl u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .host_en_i     (host_en),
    .trig_i        (trig),
    .rs_release_i  (rs_release),
    .cond_sent_i   (cond_sent_i),
    .stop_done_i   (stop_done_i),
    .start_req_o   (start_req_o),
    .restart_req_o (restart_req_o),
    .host_act_o    (host_act_o)
  );

  hpc_pause_ctl #(
    .CNT_W (CNT_W),
    .POS_W (4)
  ) u_pause (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_en_i    (host_en),
    .host_act_i   (host_act_o),
    .pend_i       (pend),
    .scl_fall_i   (scl_fall_i),
    .bit_pos_i    (bit_pos_i),
    .rx_full_i    (rx_full_i),
    .tx_empty_i   (tx_empty_i),
    .byte_cnt_i   (byte_cnt_i),
    .ack_stat_i   (ack_stat_i),
    .rsen_i       (rsen_i),
    .trig_i       (trig),
    .start_set_i  (start_set_i),
    .tx_wr_i      (tx_wr_i),
    .rx_rd_i      (rx_rd_i),
    .pause_o      (pause_o),
    .rs_release_o (rs_release)
  );

  // R11
  pause_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> host_act_o);

  // R10
  disable_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_en |=> !(start_req_o || restart_req_o || host_act_o || pause_o));

  // R2
  client_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[HOST_BIT] && !start_req_o) |=> !start_req_o);
endmodule

// File: tb/sim_i2c_host_pause_ctl.sv
module sim_i2c_host_pause_ctl;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b0, scl_fall = 1'b0, rxf = 1'b0, txe = 1'b0, ack = 1'b0, rsen = 1'b0;
  logic start_set = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, cond_sent = 1'b0, stop_done = 1'b0;
  logic [2:0] mode = 3'b100;
  logic [3:0] pos = 4'd0;
  logic [CNT_W-1:0] cnt = '0;
  logic start_req, restart_req, host_act, pause;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  i2c_host_pause_ctl #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode),
    .scl_fall_i(scl_fall), .bit_pos_i(pos), .rx_full_i(rxf), .tx_empty_i(txe),
    .byte_cnt_i(cnt), .ack_stat_i(ack), .rsen_i(rsen), .start_set_i(start_set),
    .tx_wr_i(tx_wr), .rx_rd_i(rx_rd), .cond_sent_i(cond_sent), .stop_done_i(stop_done),
    .start_req_o(start_req), .restart_req_o(restart_req), .host_act_o(host_act),
    .pause_o(pause)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic go_active();
    start_set = 1'b1; tick(); start_set = 1'b0;
    chk(start_req, 1'b1, "R3", "start_req after start bit");
    tick();
    chk(start_req, 1'b1, "R3", "start_req held");
    cond_sent = 1'b1; tick(); cond_sent = 1'b0;
    chk(start_req, 1'b0, "R3", "start_req cleared");
    chk(host_act, 1'b1, "R3", "host_act set");
  endtask

  task automatic do_stop();
    stop_done = 1'b1; tick(); stop_done = 1'b0;
    chk(host_act, 1'b0, "R10", "host_act after stop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1
    chk(start_req, 1'b0, "R1", "start_req in reset");
    chk(restart_req, 1'b0, "R1", "restart_req in reset");
    chk(host_act, 1'b0, "R1", "host_act in reset");
    chk(pause, 1'b0, "R1", "pause in reset");
    rst_ni = 1'b1;
    tick();

    // R2: every mode code with enable on and off, both trigger kinds
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 8; m++) begin
        for (int k = 0; k < 2; k++) begin
          en = e[0]; mode = m[2:0];
          if (k == 0) start_set = 1'b1; else tx_wr = 1'b1;
          tick();
          start_set = 1'b0; tx_wr = 1'b0;
          chk(start_req, e[0] & m[2], "R2", $sformatf("start_req en=%0d mode=%0d", e, m));
          en = 1'b0; tick();
          chk(start_req, 1'b0, "R10", "start_req cleared by disable");
        end
      end
    end

    en = 1'b1; mode = 3'b101;
    // R3 via transmit-buffer write
    tx_wr = 1'b1; tick(); tx_wr = 1'b0;
    chk(start_req, 1'b1, "R3", "start_req after buffer write");
    cond_sent = 1'b1; tick(); cond_sent = 1'b0;
    chk(host_act, 1'b1, "R3", "host_act after start sent");
    do_stop();

    // R4..R9 near-exhaustive sweep
    for (int p = 1; p <= 9; p++) begin
      for (int v = 0; v < 32; v++) begin
        logic e_rx, e_tx, e_rs, e_p, cz;
        mode = (p[0]) ? 3'b110 : 3'b111;
        rxf = v[0]; txe = v[1]; cz = v[2]; ack = v[3]; rsen = v[4];
        cnt = cz ? '0 : CNT_W'(p + 1);
        go_active();
        e_rx = (p == 7) && rxf;
        e_tx = (p == 8) && txe && !cz;
        e_rs = (p == 9) && rsen && (cz || ack);
        e_p  = e_rx || e_tx || e_rs;
        pos = p[3:0]; scl_fall = 1'b1; tick(); scl_fall = 1'b0;
        if (e_rx)      chk(pause, 1'b1, "R4", $sformatf("rx pause v=%0d", v));
        else if (e_tx) chk(pause, 1'b1, "R5", $sformatf("tx pause v=%0d", v));
        else if (e_rs) chk(pause, 1'b1, "R6", $sformatf("restart pause v=%0d", v));
        else           chk(pause, 1'b0, "R9", $sformatf("no pause p=%0d v=%0d", p, v));
        if (e_rx) begin
          start_set = 1'b1; tick(); start_set = 1'b0;
          chk(pause, 1'b1, "R8", "rx pause kept on start bit");
          chk(restart_req, 1'b0, "R8", "no restart from rx pause");
          tx_wr = 1'b1; tick(); tx_wr = 1'b0;
          chk(pause, 1'b1, "R8", "rx pause kept on tx write");
          rx_rd = 1'b1; tick(); rx_rd = 1'b0;
          chk(pause, 1'b0, "R4", "rx pause released by read");
        end else if (e_tx) begin
          start_set = 1'b1; tick(); start_set = 1'b0;
          chk(pause, 1'b1, "R8", "tx pause kept on start bit");
          chk(restart_req, 1'b0, "R8", "no restart from tx pause");
          rx_rd = 1'b1; tick(); rx_rd = 1'b0;
          chk(pause, 1'b1, "R8", "tx pause kept on rx read");
          tx_wr = 1'b1; tick(); tx_wr = 1'b0;
          chk(pause, 1'b0, "R5", "tx pause released by write");
          chk(restart_req, 1'b0, "R5", "no restart on tx release");
        end else if (e_rs) begin
          rx_rd = 1'b1; tick(); rx_rd = 1'b0;
          chk(pause, 1'b1, "R7", "restart pause kept on rx read");
          if (v[0]) start_set = 1'b1; else tx_wr = 1'b1;
          tick(); start_set = 1'b0; tx_wr = 1'b0;
          chk(pause, 1'b0, "R7", "restart pause released");
          chk(restart_req, 1'b1, "R7", "restart_req raised");
          chk(start_req, 1'b0, "R11", "no start while restarting");
          tick();
          chk(restart_req, 1'b1, "R7", "restart_req held");
          cond_sent = 1'b1; tick(); cond_sent = 1'b0;
          chk(restart_req, 1'b0, "R7", "restart_req cleared");
          chk(host_act, 1'b1, "R7", "host_act kept after restart");
        end
        do_stop();
      end
    end

    // R10: disable during a pause
    rxf = 1'b1; cnt = 8'd3;
    go_active();
    pos = 4'd7; scl_fall = 1'b1; tick(); scl_fall = 1'b0;
    chk(pause, 1'b1, "R4", "pause before disable");
    en = 1'b0; tick();
    chk(pause, 1'b0, "R10", "pause cleared by disable");
    chk(host_act, 1'b0, "R10", "host_act cleared by disable");
    chk(restart_req, 1'b0, "R10", "restart_req cleared by disable");
    // R11: pause needs an active host
    en = 1'b1; scl_fall = 1'b1; tick(); scl_fall = 1'b0;
    chk(pause, 1'b0, "R11", "no pause while idle");

    summary();
  end
endmodule